// File: doc/BRIEF.md
# Shift-Register Push-Button Debouncer

This block turns the noisy contact signal of a mechanical push button into a clean, single-transition level. It is also a source of single-cycle press events. The button pin is active-low. It is first brought into the system clock domain by a short flop chain. It is then inverted, so that 1 means "pressed".

A prescaler divides the system clock into a slow sample-enable pulse. With the default setting, a 4 MHz clock gives 1 kHz. On each enable pulse, a small filter register compares the new sample with the clean output:

- If the sample equals the output, the whole register is reloaded with that value.
- If the sample differs, the register shifts by one place toward its output stage, and the sample enters the first stage.

The output therefore changes only after a full run of opposite samples. A single sample that matches the output again clears all partial progress. The clean output is the last stage of the register. A one-cycle press pulse is raised together with every rising edge of the clean output, so that a counter can count presses.

Top module: `pb_debouncer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `clean_o` and `press_o` are 0. After release, the first sample is taken on the CLK_DIV-th rising clock edge.
- R2: The button input is active-low. A steady 0 on `btn_n_i` drives `clean_o` to 1, and a steady 1 drives it to 0.
- R3: The button input passes through SYNC_STAGES flops before it is sampled. A change on `btn_n_i` becomes visible to the filter SYNC_STAGES clock edges later.
- R4: The filter is updated only on a sample enable. Enables occur exactly once every CLK_DIV clock cycles, and `clean_o` changes on no other edge.
- R5: `clean_o` rises only after FILTER_STAGES consecutive sample enables have all seen the button pressed.
- R6: `clean_o` falls only after FILTER_STAGES consecutive sample enables have all seen the button released. The rule is the same as for the rising edge.
- R7: Any sample that equals the current output during a transition discards all progress. A new full run of FILTER_STAGES opposite samples is then needed.
- R8: `press_o` is high for exactly one clock cycle, on the same cycle that `clean_o` first reads 1 after a rise. It is never raised when `clean_o` falls or holds.
- R9: Samples equal to the current output leave `clean_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n_i | input | 1 | Raw button contact, 0 = pressed, asynchronous |
| clean_o | output | 1 | Debounced button level, 1 = pressed |
| press_o | output | 1 | One-cycle pulse on each debounced press |

## Verification
The assertions assume the following:
- Reset is applied before the first sample enable.
- After the synchronizer, the internal sample only changes on a clock edge.

The raw button pin itself may move at any time. The bench drives it only at falling clock edges. Each level is held for whole sample periods, and every 6-sample bounce pattern is swept. This places every possible run of pressed and released samples, including each interrupted run, into the filter at a known enable. It also keeps the enable spacing that the assertions rely on intact.

// File: rtl/db_pkg.sv
package db_pkg;

  // Action applied to the filter register on a sample enable
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,  // no sample enable this cycle
    ACT_LOAD  = 2'd1,  // sample agrees with output: reload all stages
    ACT_SHIFT = 2'd2   // sample disagrees: advance one stage
  } filt_act_e;

endpackage

// File: rtl/db_prescaler.sv
module db_prescaler #(
  parameter int unsigned DIV = 4000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/db_sync.sv
module db_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/db_filter.sv
module db_filter
  import db_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sample,
  output logic level_o,
  output logic rise_o
);
  localparam int unsigned MSB = STAGES - 1;

  logic [STAGES-1:0] shreg_q, shreg_d;
  logic              rise_q;
  filt_act_e         act;

  always_comb begin
    if (!tick) begin
      act = ACT_HOLD;
    end else if (sample == shreg_q[MSB]) begin
      act = ACT_LOAD;
    end else begin
      act = ACT_SHIFT;
    end
  end

  always_comb begin
    unique case (act)
      ACT_LOAD:  shreg_d = {STAGES{sample}};
      ACT_SHIFT: shreg_d = {shreg_q[STAGES-2:0], sample};
      default:   shreg_d = shreg_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      rise_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      rise_q  <= shreg_d[MSB] & ~shreg_q[MSB];
    end
  end

  assign level_o = shreg_q[MSB];
  assign rise_o  = rise_q;
endmodule

// File: rtl/pb_debouncer.sv
module pb_debouncer #(
  parameter int unsigned CLK_DIV       = 4000,
  parameter int unsigned FILTER_STAGES = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n_i,
  output logic clean_o,
  output logic press_o
);
  logic btn_n_sync;
  logic sample;
  logic tick;

  db_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (btn_n_i),
    .q  (btn_n_sync)
  );

  // Active-low pin becomes an active-high "pressed" sample
  assign sample = ~btn_n_sync;

  db_prescaler #(
    .DIV(CLK_DIV)
  ) u_presc (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  db_filter #(
    .STAGES(FILTER_STAGES)
  ) u_filt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .sample (sample),
    .level_o(clean_o),
    .rise_o (press_o)
  );
endmodule

// File: rtl/pb_debouncer_checker.sv
module pb_debouncer_checker #(
  parameter int unsigned DIV = 4000
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic sample,
  input logic clean,
  input logic press
);
  int unsigned gap_q;

  always_ff @(posedge clk) begin
    if (rst || tick) gap_q <= 0;
    else             gap_q <= gap_q + 1;
  end

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == DIV - 1));

  assert_clean_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(clean) |-> $past(tick));

  assert_rise_needs_press_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(clean) |-> $past(sample));

  assert_fall_needs_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(clean) |-> !$past(sample));

  assert_press_single_R8: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  assert_press_with_rise_R8: assert property (@(posedge clk) disable iff (rst)
    press |-> $rose(clean));

  assert_rise_gives_press_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(clean) |-> press);
endmodule

bind pb_debouncer pb_debouncer_checker #(
  .DIV(CLK_DIV)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .tick  (tick),
  .sample(sample),
  .clean (clean_o),
  .press (press_o)
);

// File: tb/pb_debouncer_test.sv
module pb_debouncer_test;
  localparam int DIV = 5;
  localparam int STG = 4;
  localparam int SYN = 2;
  localparam int PAT_BITS = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_n = 1'b1;
  logic clean, press;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pb_debouncer #(
    .CLK_DIV      (DIV),
    .FILTER_STAGES(STG),
    .SYNC_STAGES  (SYN)
  ) uut (
    .clk    (clk),
    .rst    (rst),
    .btn_n_i(btn_n),
    .clean_o(clean),
    .press_o(press)
  );

  // Arithmetic reference: run length of opposite samples
  logic [SYN-1:0] m_sync;  // R3: SYN-edge delay of the pin
  int             m_cnt;   // R4: enable every DIV cycles
  int             m_run;
  logic           m_out, m_press;

  always @(posedge clk) begin
    if (rst) begin
      m_sync  <= '1;
      m_cnt   <= 0;
      m_run   <= 0;
      m_out   <= 1'b0;
      m_press <= 1'b0;
    end else begin
      m_sync  <= {m_sync[SYN-2:0], btn_n};
      m_cnt   <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      m_press <= 1'b0;
      if (m_cnt == DIV - 1) begin
        // R2: pressed means pin low
        if ((~m_sync[SYN-1]) != m_out) begin
          if (m_run + 1 == STG) begin        // R5, R6: full run flips
            m_out   <= ~m_out;
            m_run   <= 0;
            m_press <= ~m_out;               // R8: only on rise
          end else begin
            m_run <= m_run + 1;
          end
        end else begin
          m_run <= 0;                        // R7 restart, R9 hold
        end
      end
    end
  end

  task automatic check(input string tag);
    n_chk++;
    if (clean !== m_out) begin
      n_fail++;
      $display("FAIL %s clean_o: actual %b expected %b at %0t", tag, clean, m_out, $time);
    end
    n_chk++;
    if (press !== m_press) begin
      n_fail++;
      $display("FAIL R8 press_o: actual %b expected %b at %0t", press, m_press, $time);
    end
  endtask

  task automatic cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1;
    btn_n = 1'b0;
    cycles(3, "R1");
    rst = 1'b0;
    cycles(1, "R1");
    btn_n = 1'b1;
    cycles(DIV * 3, "R1 R9");

    // Exhaustive sweep of bounce patterns, one bit per sample period
    // R5 R6 R7 R9 checked through clean_o at every cycle
    for (int pat = 0; pat < (1 << PAT_BITS); pat++) begin
      for (int b = 0; b < PAT_BITS; b++) begin
        btn_n = pat[b];
        cycles(DIV, "R5 R6 R7");
      end
      cycles(DIV * (STG + 2), "R2 R9");
    end

    // Steady press then mid-run reset: R2, R1
    btn_n = 1'b0;
    cycles(DIV * (STG + 3), "R2 R5");
    rst = 1'b1;
    cycles(2, "R1");
    rst = 1'b0;
    // After reset the pressed pin must again take a full run (R3, R4, R5)
    cycles(DIV * (STG + 3), "R3 R4 R5");
    btn_n = 1'b1;
    cycles(DIV * (STG + 3), "R6");

    finish_run();
  end

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule